// File: doc/BRIEF.md
# Mains-Locked One-Second Timebase

The block derives a one-second strobe from a free-running local tick. The tick is much finer than a millisecond, and the strobe is kept in step with the power line. A loop counter advances on each tick and wraps once per expected mains cycle. Its wraps are divided by 50 or 60, chosen by a select input, to form a single-cycle strobe once per second.

Each qualified mains edge samples the loop counter. The sampled offset from the wrap point falls into one of five bands: on time, late, very late, early or very early. The band adds a weighted step of 0, ±1 or ±3 to a signed phase accumulator. When the accumulator reaches the threshold in either direction, the loop counter is nudged by one tick toward the mains and the accumulator restarts. The nudges are also summed in a frequency accumulator. When that sum passes a dilution limit, the loop period itself is lengthened or shortened, within fixed bounds. This gives frequency lock as well as phase lock. Edge qualification happens upstream.

Top module: `mains_timebase`

## Requirements
- R1: After reset the loop count is 0, the period is PERIOD_NOM, both accumulators are 0 and the strobe is low.
- R2: The loop count advances by one only on a cycle with tick_i high, and wraps from period-1 to 0.
- R3: The edge offset is the loop count c if c < period/2 (edge late), else period-c (edge early). An edge whose offset is at most ON_BAND leaves the phase accumulator unchanged.
- R4: A late edge with offset in (ON_BAND, NEAR_BAND] adds 1 and a larger one adds 3; an early edge subtracts 1 or 3 under the same bands.
- R5: When the phase sum reaches +THRESH the accumulator clears, the loop count skips its next tick increment (retard), and the frequency accumulator gains 1.
- R6: When the phase sum reaches -THRESH the accumulator clears, the next tick increments the loop count by 2 (advance), and the frequency accumulator loses 1.
- R7: When the frequency sum would exceed +DILUTE the period grows by 1; below -DILUTE it shrinks by 1; in both cases the frequency accumulator clears.
- R8: The period never leaves [PERIOD_MIN, PERIOD_MAX]; a step past a bound leaves the period unchanged and still clears the frequency accumulator.
- R9: pulse_o is high for exactly one cycle every 50 loop wraps with sel60_i low and every 60 wraps with sel60_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Fine timebase enable for the loop counter |
| edge_i | input | 1 | One-cycle pulse per qualified mains edge |
| sel60_i | input | 1 | 1 selects 60 wraps per second, 0 selects 50 |
| pulse_o | output | 1 | One-cycle strobe per second |
| loop_cnt_o | output | CW | Current loop count |
| phase_acc_o | output | ACC_W | Signed phase error accumulator |
| freq_acc_o | output | FRQ_W | Signed sum of loop nudges |
| period_o | output | CW | Current loop period in ticks |

## Verification
Edges are placed at exact loop counts on both sides of each band boundary: offsets 2, 3, 10 and 11 after the wrap and the mirrored counts before it. This separates the on-time, single-step and triple-step bands and shows the sign convention. Repeated very-late and very-early edges drive the accumulator past the threshold, and the loop count is watched tick by tick to tell a one-tick hold from a two-tick jump. Longer runs of the same pattern move the period up, move it down and pin it at its upper bound. Strobe intervals are timed in both divide modes with no edges present, so the 50 and 60 settings give distinct counts.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  typedef enum logic [2:0] {
    WIN_VERY_EARLY,
    WIN_EARLY,
    WIN_ON,
    WIN_LATE,
    WIN_VERY_LATE
  } win_e;

  function automatic logic signed [2:0] win_step(win_e w);
    case (w)
      WIN_VERY_EARLY: win_step = -3'sd3;
      WIN_EARLY:      win_step = -3'sd1;
      WIN_LATE:       win_step = 3'sd1;
      WIN_VERY_LATE:  win_step = 3'sd3;
      default:        win_step = 3'sd0;
    endcase
  endfunction
endpackage

// File: rtl/mtb_phase_cls.sv
module mtb_phase_cls
  import mtb_pkg::*;
#(
  parameter int CW        = 12,
  parameter int ON_BAND   = 2,
  parameter int NEAR_BAND = 10
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] period_i,
  output win_e          win_o
);
  localparam logic [CW-1:0] ON_B   = CW'(ON_BAND);
  localparam logic [CW-1:0] NEAR_B = CW'(NEAR_BAND);

  logic [CW-1:0] half;
  logic [CW-1:0] mag;
  logic          late;

  always_comb begin
    half = period_i >> 1;
    late = cnt_i < half;
    mag  = late ? cnt_i : period_i - cnt_i;
    if (mag <= ON_B)        win_o = WIN_ON;
    else if (mag <= NEAR_B) win_o = late ? WIN_LATE : WIN_EARLY;
    else                    win_o = late ? WIN_VERY_LATE : WIN_VERY_EARLY;
  end
endmodule

// File: rtl/mtb_err_track.sv
module mtb_err_track
  import mtb_pkg::*;
#(
  parameter int CW         = 12,
  parameter int ACC_W      = 8,
  parameter int FRQ_W      = 6,
  parameter int THRESH     = 10,
  parameter int DILUTE     = 4,
  parameter int PERIOD_NOM = 200,
  parameter int PERIOD_MIN = 180,
  parameter int PERIOD_MAX = 220
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    edge_i,
  input  win_e                    win_i,
  output logic                    adv_o,
  output logic                    ret_o,
  output logic signed [ACC_W-1:0] phase_acc_o,
  output logic signed [FRQ_W-1:0] freq_acc_o,
  output logic        [CW-1:0]    period_o
);
  localparam logic signed [ACC_W-1:0] THR_P   = ACC_W'(THRESH);
  localparam logic signed [ACC_W-1:0] THR_N   = -THR_P;
  localparam logic signed [FRQ_W-1:0] DIL_P   = FRQ_W'(DILUTE);
  localparam logic signed [FRQ_W-1:0] DIL_N   = -DIL_P;
  localparam logic signed [FRQ_W-1:0] FRQ_ONE = FRQ_W'(1);
  localparam logic [CW-1:0] P_NOM = CW'(PERIOD_NOM);
  localparam logic [CW-1:0] P_MIN = CW'(PERIOD_MIN);
  localparam logic [CW-1:0] P_MAX = CW'(PERIOD_MAX);

  logic signed [ACC_W-1:0] acc_q, acc_sum;
  logic signed [FRQ_W-1:0] frq_q, frq_sum;
  logic        [CW-1:0]    per_q;
  logic signed [2:0]       step;
  logic                    grow, shrink;

  always_comb begin
    step    = win_step(win_i);
    acc_sum = acc_q + $signed({{(ACC_W-3){step[2]}}, step});
    ret_o   = edge_i && (acc_sum >= THR_P);
    adv_o   = edge_i && (acc_sum <= THR_N);
    frq_sum = ret_o ? frq_q + FRQ_ONE : frq_q - FRQ_ONE;
    grow    = ret_o && (frq_sum > DIL_P);
    shrink  = adv_o && (frq_sum < DIL_N);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      frq_q <= '0;
      per_q <= P_NOM;
    end else if (edge_i) begin
      if (ret_o || adv_o) begin
        acc_q <= '0;
        if (grow || shrink) begin
          frq_q <= '0;
          if (grow && per_q < P_MAX)   per_q <= per_q + 1'b1;
          if (shrink && per_q > P_MIN) per_q <= per_q - 1'b1;
        end else begin
          frq_q <= frq_sum;
        end
      end else begin
        acc_q <= acc_sum;
      end
    end
  end

  assign phase_acc_o = acc_q;
  assign freq_acc_o  = frq_q;
  assign period_o    = per_q;
endmodule

// File: rtl/mtb_loop_ctr.sv
module mtb_loop_ctr #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] period_i,
  input  logic          adv_i,
  input  logic          ret_i,
  output logic [CW-1:0] cnt_o,
  output logic          roll_o
);
  logic [CW-1:0] cnt_q;
  logic          adv_pend_q, ret_pend_q;
  logic [CW:0]   sum, diff;
  logic          wrap;

  always_comb begin
    sum    = {1'b0, cnt_q} + (CW+1)'(1) + {{CW{1'b0}}, adv_pend_q};
    diff   = sum - {1'b0, period_i};
    wrap   = sum >= {1'b0, period_i};
    roll_o = tick_i && !ret_pend_q && wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      adv_pend_q <= 1'b0;
      ret_pend_q <= 1'b0;
    end else begin
      if (tick_i && !ret_pend_q) cnt_q <= wrap ? diff[CW-1:0] : sum[CW-1:0];
      // a nudge raised now waits for the next tick
      if (adv_i)       adv_pend_q <= 1'b1;
      else if (tick_i) adv_pend_q <= 1'b0;
      if (ret_i)       ret_pend_q <= 1'b1;
      else if (tick_i) ret_pend_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mtb_sec_div.sv
module mtb_sec_div #(
  parameter int CYC_LO = 50,
  parameter int CYC_HI = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic roll_i,
  input  logic sel60_i,
  output logic pulse_o
);
  localparam int DW = $clog2(CYC_HI);
  localparam logic [DW-1:0] LAST_LO = DW'(CYC_LO - 1);
  localparam logic [DW-1:0] LAST_HI = DW'(CYC_HI - 1);

  logic [DW-1:0] div_q;
  logic          last;

  assign last = div_q >= (sel60_i ? LAST_HI : LAST_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= roll_i && last;
      if (roll_i) div_q <= last ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/mains_timebase.sv
module mains_timebase #(
  parameter int CW         = 12,
  parameter int PERIOD_NOM = 200,
  parameter int PERIOD_MIN = 180,
  parameter int PERIOD_MAX = 220,
  parameter int ON_BAND    = 2,
  parameter int NEAR_BAND  = 10,
  parameter int THRESH     = 10,
  parameter int DILUTE     = 4,
  parameter int CYC_LO     = 50,
  parameter int CYC_HI     = 60,
  parameter int ACC_W      = 8,
  parameter int FRQ_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic             sel60_i,
  output logic             pulse_o,
  output logic [CW-1:0]    loop_cnt_o,
  output logic [ACC_W-1:0] phase_acc_o,
  output logic [FRQ_W-1:0] freq_acc_o,
  output logic [CW-1:0]    period_o
);
  mtb_pkg::win_e           win;
  logic                    adv, ret, roll;
  logic signed [ACC_W-1:0] acc_s;
  logic signed [FRQ_W-1:0] frq_s;

  mtb_phase_cls #(.CW(CW), .ON_BAND(ON_BAND), .NEAR_BAND(NEAR_BAND)) u_cls (
    .cnt_i(loop_cnt_o), .period_i(period_o), .win_o(win)
  );

  mtb_err_track #(
    .CW(CW), .ACC_W(ACC_W), .FRQ_W(FRQ_W), .THRESH(THRESH), .DILUTE(DILUTE),
    .PERIOD_NOM(PERIOD_NOM), .PERIOD_MIN(PERIOD_MIN), .PERIOD_MAX(PERIOD_MAX)
  ) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_i), .win_i(win),
    .adv_o(adv), .ret_o(ret), .phase_acc_o(acc_s), .freq_acc_o(frq_s),
    .period_o(period_o)
  );

  mtb_loop_ctr #(.CW(CW)) u_loop (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .period_i(period_o),
    .adv_i(adv), .ret_i(ret), .cnt_o(loop_cnt_o), .roll_o(roll)
  );

  mtb_sec_div #(.CYC_LO(CYC_LO), .CYC_HI(CYC_HI)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .roll_i(roll), .sel60_i(sel60_i),
    .pulse_o(pulse_o)
  );

  assign phase_acc_o = acc_s;
  assign freq_acc_o  = frq_s;
endmodule

// File: rtl/mains_timebase_chk.sv
module mains_timebase_chk #(
  parameter int CW         = 12,
  parameter int PERIOD_MIN = 180,
  parameter int PERIOD_MAX = 220,
  parameter int THRESH     = 10,
  parameter int DILUTE     = 4,
  parameter int ACC_W      = 8,
  parameter int FRQ_W      = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             edge_i,
  input logic             sel60_i,
  input logic             pulse_o,
  input logic [CW-1:0]    loop_cnt_o,
  input logic [ACC_W-1:0] phase_acc_o,
  input logic [FRQ_W-1:0] freq_acc_o,
  input logic [CW-1:0]    period_o
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(loop_cnt_o));

  // R5
  acc_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(phase_acc_o) < THRESH) && ($signed(phase_acc_o) > -THRESH));

  // R4
  acc_edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> $stable(phase_acc_o));

  // R7
  frq_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(freq_acc_o) <= DILUTE) && ($signed(freq_acc_o) >= -DILUTE));

  // R7
  period_edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> $stable(period_o));

  // R8
  period_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_o >= CW'(PERIOD_MIN)) && (period_o <= CW'(PERIOD_MAX)));

  // R9
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

bind mains_timebase mains_timebase_chk #(
  .CW(CW), .PERIOD_MIN(PERIOD_MIN), .PERIOD_MAX(PERIOD_MAX), .THRESH(THRESH),
  .DILUTE(DILUTE), .ACC_W(ACC_W), .FRQ_W(FRQ_W)
) u_chk (.*);

// File: tb/mains_timebase_bench.sv
`timescale 1ns/1ps
module mains_timebase_bench;
  localparam int CW = 12, ACC_W = 8, FRQ_W = 6;
  localparam int P_MAX = 202;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b1, edge_i = 1'b0, sel60_i = 1'b0;
  logic pulse_o;
  logic [CW-1:0] loop_cnt_o, period_o;
  logic [ACC_W-1:0] phase_acc_o;
  logic [FRQ_W-1:0] freq_acc_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  mains_timebase #(.PERIOD_MAX(P_MAX)) u_mains_timebase (.*);

  function automatic int acc(); return int'($signed(phase_acc_o)); endfunction
  function automatic int frq(); return int'($signed(freq_acc_o)); endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      finish_run();
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0; edge_i = 1'b0; tick_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic send_edge(int target);
    @(negedge clk_i);
    while (int'(loop_cnt_o) != target) @(negedge clk_i);
    edge_i = 1'b1;
    @(negedge clk_i);
    edge_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 cnt", int'(loop_cnt_o), 0);
    check("R1 period", int'(period_o), 200);
    check("R1 phase acc", acc(), 0);
    check("R1 freq acc", frq(), 0);
    check("R1 pulse", int'(pulse_o), 0);
  endtask

  task automatic t_tick();
    int c;
    do_reset();
    repeat (7) @(negedge clk_i);
    tick_i = 1'b0;
    c = int'(loop_cnt_o);
    repeat (5) @(negedge clk_i);
    check("R2 hold without tick", int'(loop_cnt_o), c);
    tick_i = 1'b1;
    @(negedge clk_i);
    check("R2 step on tick", int'(loop_cnt_o), c + 1);
    while (int'(loop_cnt_o) != 199) @(negedge clk_i);
    @(negedge clk_i);
    check("R2 wrap", int'(loop_cnt_o), 0);
  endtask

  task automatic t_windows();
    do_reset();
    send_edge(2);   check("R3 on time late side", acc(), 0);
    send_edge(198); check("R3 on time early side", acc(), 0);
    send_edge(0);   check("R3 on time at wrap", acc(), 0);
    send_edge(3);   check("R4 late lower edge", acc(), 1);
    send_edge(10);  check("R4 late upper edge", acc(), 2);
    send_edge(11);  check("R4 very late", acc(), 5);
    send_edge(190); check("R4 early", acc(), 4);
    send_edge(189); check("R4 very early", acc(), 1);
  endtask

  task automatic t_retard();
    do_reset();
    repeat (3) send_edge(30);
    check("R5 below threshold", acc(), 9);
    send_edge(30);
    check("R5 acc cleared", acc(), 0);
    check("R5 freq up", frq(), 1);
    check("R5 cnt after edge", int'(loop_cnt_o), 31);
    @(negedge clk_i);
    check("R5 retard hold", int'(loop_cnt_o), 31);
    @(negedge clk_i);
    check("R5 resume", int'(loop_cnt_o), 32);
  endtask

  task automatic t_advance();
    do_reset();
    repeat (3) send_edge(150);
    check("R6 below threshold", acc(), -9);
    send_edge(150);
    check("R6 acc cleared", acc(), 0);
    check("R6 freq down", frq(), -1);
    check("R6 cnt after edge", int'(loop_cnt_o), 151);
    @(negedge clk_i);
    check("R6 advance jump", int'(loop_cnt_o), 153);
  endtask

  task automatic t_period_up();
    do_reset();
    repeat (16) send_edge(30);
    check("R7 four bumps", frq(), 4);
    check("R7 period before", int'(period_o), 200);
    repeat (4) send_edge(30);
    check("R7 period grows", int'(period_o), 201);
    check("R7 freq cleared", frq(), 0);
    repeat (20) send_edge(30);
    check("R8 reach max", int'(period_o), 202);
    repeat (20) send_edge(30);
    check("R8 clamp at max", int'(period_o), 202);
    check("R8 freq cleared at clamp", frq(), 0);
  endtask

  task automatic t_period_down();
    do_reset();
    repeat (20) send_edge(150);
    check("R7 period shrinks", int'(period_o), 199);
    check("R7 freq cleared low", frq(), 0);
  endtask

  task automatic t_div(bit sel, int exp_gap);
    int gap;
    sel60_i = sel;
    do_reset();
    @(negedge clk_i);
    while (!pulse_o) @(negedge clk_i);
    @(negedge clk_i);
    check("R9 one cycle wide", int'(pulse_o), 0);
    gap = 1;
    while (!pulse_o) begin @(negedge clk_i); gap++; end
    check(sel ? "R9 sixty wraps" : "R9 fifty wraps", gap, exp_gap);
  endtask

  initial begin
    t_reset();
    t_tick();
    t_windows();
    t_retard();
    t_advance();
    t_period_up();
    t_period_down();
    t_div(1'b0, 50 * 200);
    t_div(1'b1, 60 * 200);
    finish_run();
  end
endmodule